// File: doc/BRIEF.md
# Parallel-Load Serial Shift Register

This block is an eight-stage parallel-in, serial-out shift register driven by one free-running system clock. A word presented on the parallel inputs is captured into all stages while the active-low load control is low. While load is high, each rising edge of the OR of two interchangeable strobe inputs moves the contents one stage toward the output end, and the serial input enters the first stage. The last stage is driven out twice: once true and once inverted.

The strobe inputs, the serial input and the load control may come from a slow or unrelated clock domain. Each passes through a two-flop synchronizer. An edge detector on the synchronized OR of the two strobe inputs then produces a single-cycle shift pulse. Several instances chain by feeding one block's true output into the next block's serial input.

Top module: `piso_shift_reg`

## Requirements
- R1: A synchronous active-high reset clears all stages and the edge history to 0. After reset, out_q reads 0 and out_qn reads 1.
- R2: While the synchronized load_n is low, every stage takes par_in at each clock, whatever the strobes or ser_in do. par_in bit 0 is the first stage and bit 7 is the output stage.
- R3: While load_n is high, par_in has no effect on the stages.
- R4: With load_n high and tick_b low, a 0-to-1 transition of tick_a shifts the register once. Each stage takes the value of the stage below it (bit i gets bit i-1), and the synchronized ser_in enters bit 0.
- R5: tick_b is interchangeable with tick_a. A 0-to-1 transition of tick_b while tick_a is low also shifts once.
- R6: While either strobe input is held high, transitions on the other one cause no shift.
- R7: out_qn is always the complement of out_q.
- R8: An input change applied before clock edge k takes effect on the stages at edge k+2. A strobe held high shifts only once.
- R9: Load wins over a shift pulse in the same cycle. A strobe edge that occurs during load is not replayed after load is released.
- R10: A shift uses the synchronized ser_in value of the same cycle in which the strobe edge is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | 8 | Parallel data; bit 0 = first stage, bit 7 = output stage |
| ser_in | input | 1 | Serial data entering the first stage |
| load_n | input | 1 | Active-low parallel load control |
| tick_a | input | 1 | Shift strobe input, interchangeable with tick_b |
| tick_b | input | 1 | Shift strobe input, interchangeable with tick_a |
| out_q | output | 1 | True value of the output stage |
| out_qn | output | 1 | Complement of the output stage |

## Verification
Only the output stage is visible, so a corrupted inner stage stays hidden until it has shifted to the end. That can take up to seven further shifts. For this reason the stimulus shifts every loaded word all the way out and compares each cycle against a behavioural model.

A spurious or missing shift pulse shows at out_q two cycles after the strobe edge that caused it. A wrong load priority shows immediately after load_n is released, because the output would not equal par_in bit 7.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // Synchronized control bundle carried through the input synchronizer
    typedef struct packed {
        logic ld_n;
        logic ser;
        logic tick_a;
        logic tick_b;
    } ctrl_t;

    // Reset value: load inactive, strobes and serial data low
    localparam ctrl_t CTRL_IDLE = '{ld_n: 1'b1, ser: 1'b0, tick_a: 1'b0, tick_b: 1'b0};

    function automatic logic strobe_level(input ctrl_t c);
        return c.tick_a | c.tick_b;
    endfunction

endpackage

// File: rtl/piso_sync.sv
module piso_sync
    import piso_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t raw,
    output ctrl_t synced
);
    ctrl_t pipe [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_flop
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= CTRL_IDLE;
                    else     pipe[0] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= CTRL_IDLE;
                    else     pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign synced = pipe[DEPTH-1];

endmodule

// File: rtl/piso_strobe.sv
module piso_strobe
    import piso_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctl,
    output logic  shift_pulse
);
    logic level;
    logic hist;

    assign level       = strobe_level(ctl);
    assign shift_pulse = level & ~hist;

    // History keeps tracking during load so no edge is replayed afterwards
    always_ff @(posedge clk) begin
        if (rst) hist <= 1'b0;
        else     hist <= level;
    end

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> !shift_pulse);

    // R6
    held_level_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(level) && level) |-> !shift_pulse);

endmodule

// File: rtl/piso_chain.sv
module piso_chain #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              shift_pulse,
    input  logic              ser,
    input  logic [STAGES-1:0] par_in,
    output logic [STAGES-1:0] stages
);
    always_ff @(posedge clk) begin
        if (rst)               stages <= '0;
        else if (!ld_n)        stages <= par_in;
        else if (shift_pulse)  stages <= {stages[STAGES-2:0], ser};
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (stages == '0));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_n |=> (stages == $past(par_in)));

    // R4
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_n && shift_pulse) |=> (stages == {$past(stages[STAGES-2:0]), $past(ser)}));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_n && !shift_pulse) |=> $stable(stages));

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int STAGES     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] par_in,
    input  logic              ser_in,
    input  logic              load_n,
    input  logic              tick_a,
    input  logic              tick_b,
    output logic              out_q,
    output logic              out_qn
);
    localparam int LAST = STAGES - 1;

    ctrl_t             raw_ctl;
    ctrl_t             sync_ctl;
    logic              shift_pulse;
    logic [STAGES-1:0] stages;

    assign raw_ctl = '{ld_n: load_n, ser: ser_in, tick_a: tick_a, tick_b: tick_b};

    piso_sync #(.DEPTH(SYNC_DEPTH)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_ctl),
        .synced (sync_ctl)
    );

    piso_strobe strobe_i (
        .clk         (clk),
        .rst         (rst),
        .ctl         (sync_ctl),
        .shift_pulse (shift_pulse)
    );

    piso_chain #(.STAGES(STAGES)) chain_i (
        .clk         (clk),
        .rst         (rst),
        .ld_n        (sync_ctl.ld_n),
        .shift_pulse (shift_pulse),
        .ser         (sync_ctl.ser),
        .par_in      (par_in),
        .stages      (stages)
    );

    assign out_q  = stages[LAST];
    assign out_qn = ~stages[LAST];

endmodule

// File: tb/piso_shift_reg_tb_top.sv
`timescale 1ns/1ps
module piso_shift_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] par_in = 8'h00;
    logic       ser_in = 1'b0;
    logic       load_n = 1'b1;
    logic       tick_a = 1'b0;
    logic       tick_b = 1'b0;
    logic       out_q, out_qn;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string phase = "R1";
    bit started = 0;

    // Behavioural model state
    logic [7:0] m_reg = 8'h00;
    logic       m_hist = 1'b0;
    logic [3:0] p1 = 4'b1000;   // {ld_n, ser, a, b}
    logic [3:0] p2 = 4'b1000;

    always #2.5 clk = ~clk;

    piso_shift_reg dut_i (
        .clk(clk), .rst(rst), .par_in(par_in), .ser_in(ser_in),
        .load_n(load_n), .tick_a(tick_a), .tick_b(tick_b),
        .out_q(out_q), .out_qn(out_qn)
    );

    always @(posedge clk) begin
        logic lvl;
        started = 1;
        cycles++;
        if (rst) begin
            m_reg = 8'h00; m_hist = 1'b0; p1 = 4'b1000; p2 = 4'b1000;
        end else begin
            lvl = p2[1] | p2[0];
            if (!p2[3])               m_reg = par_in;
            else if (lvl && !m_hist)  m_reg = {m_reg[6:0], p2[2]};
            m_hist = lvl;
            p2 = p1;
            p1 = {load_n, ser_in, tick_a, tick_b};
        end
    end

    task automatic check(input bit ok, input string req, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check(out_q === m_reg[7], phase, out_q, m_reg[7]);
            check(out_qn === ~out_q, "R7", out_qn, ~out_q);
        end
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_a(input logic s);
        ser_in = s; tick_a = 1'b1; cyc(3);
        tick_a = 1'b0; cyc(3);
    endtask

    task automatic pulse_b(input logic s);
        ser_in = s; tick_b = 1'b1; cyc(3);
        tick_b = 1'b0; cyc(3);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check(out_q === 1'b0, "R1", out_q, 1'b0);
        check(out_qn === 1'b1, "R1", out_qn, 1'b1);

        // R2: load regardless of strobes and serial input
        phase = "R2";
        par_in = 8'hA5; load_n = 1'b0; ser_in = 1'b1; tick_a = 1'b1;
        cyc(2); tick_a = 1'b0; cyc(2);
        load_n = 1'b1; cyc(4);
        check(out_q === 1'b1, "R2", out_q, 1'b1);

        // R4 and R10: shift with tick_a, serial pattern enters stage 0
        phase = "R4";
        pulse_a(1'b0);
        check(out_q === 1'b0, "R4", out_q, 1'b0);
        phase = "R10";
        for (int i = 0; i < 8; i++) pulse_a(i[0]);

        // R3: parallel input changes ignored while shifting
        phase = "R3";
        par_in = 8'hFF;
        for (int i = 0; i < 4; i++) begin pulse_a(1'b0); par_in = ~par_in; end

        // R5: tick_b used as the clock
        phase = "R5";
        for (int i = 0; i < 6; i++) pulse_b(i[1]);

        // R6: one input held high, other toggles
        phase = "R6";
        par_in = 8'h81; load_n = 1'b0; cyc(4); load_n = 1'b1; cyc(3);
        tick_a = 1'b1; ser_in = 1'b0; cyc(4);
        for (int i = 0; i < 4; i++) begin tick_b = ~tick_b; cyc(3); end
        tick_a = 1'b0; cyc(4);
        tick_b = 1'b1; cyc(4);
        for (int i = 0; i < 4; i++) begin tick_a = ~tick_a; cyc(3); end
        tick_b = 1'b0; cyc(4);

        // R8: held strobe shifts only once
        phase = "R8";
        ser_in = 1'b1; tick_a = 1'b1; cyc(20); tick_a = 1'b0; cyc(4);
        for (int i = 0; i < 7; i++) pulse_b(1'b0);

        // R9: edge during load not replayed after release
        phase = "R9";
        par_in = 8'h80; load_n = 1'b0; cyc(3);
        tick_b = 1'b1; cyc(3);
        load_n = 1'b1; cyc(8);
        check(out_q === 1'b1, "R9", out_q, 1'b1);
        tick_b = 1'b0; cyc(4);
        pulse_a(1'b0);
        check(out_q === 1'b0, "R9", out_q, 1'b0);

        // R1: reset mid-stream
        phase = "R1";
        par_in = 8'hFF; load_n = 1'b0; cyc(4); load_n = 1'b1; cyc(3);
        rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
        check(out_q === 1'b0, "R1", out_q, 1'b0);
        cyc(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule